// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the command register of a byte-wide flash memory with a 17-bit address. It watches host bus cycles on active-low chip enable, output enable and write enable, plus address and data. It recognises the multi-write unlock sequences that lead to chip erase or sector erase, and raises an internal erase request. A small behavioural array stands in for the flash cells. Its busy time is a parameter. Erased sectors read back as FFh. Any other location reads as a fixed fold of its address: bit i of the address is XORed into bit (i mod 8) of the byte.

A sector erase starts an acceptance window. Each further sector command written inside that window adds a sector to the same operation and restarts the window. When the window runs out, the erase begins. While a window is open or an erase is running, reads return a status byte instead of array data.

The decoder states are named as follows:
- IDLE/READ (`ST_READ`)
- first unlock seen (`ST_UNL1`)
- second unlock seen (`ST_UNL2`)
- erase setup seen (`ST_SETUP`)
- fourth unlock seen (`ST_UNL4`)
- fifth unlock seen (`ST_UNL5`)
- sector window open (`ST_SECT_WIN`)
- erasing (`ST_ERASE`)

The transitions are:
- READ→UNL1 on AAh@5555h
- UNL1→UNL2 on 55h@2AAAh
- UNL2→SETUP on 80h@5555h
- SETUP→UNL4 on AAh@5555h
- UNL4→UNL5 on 55h@2AAAh
- UNL5→ERASE on 10h@5555h (chip erase)
- UNL5→SECT_WIN on 30h to any address
- SECT_WIN→SECT_WIN on 30h to any address (sector added, window restarted)
- SECT_WIN→ERASE when the window expires
- ERASE→READ when the busy time expires
- any unexpected write in UNL1..UNL5 or SECT_WIN returns the decoder to READ

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in the read state: `erase_busy` is 0, `erase_sectors` is 0, and a read returns array data, which is the address fold, with no command needed.
- R2: A write is accepted only while ce_n=0, we_n=0 and oe_n=1. A cycle with oe_n=0 is not a write.
- R3: A write takes its address from the first cycle in which the write condition holds. It takes its data from the last such cycle.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h start a chip erase. `erase_sectors` becomes FFh, and afterwards every sector reads FFh.
- R5: The same five unlock/setup writes followed by 30h to any address select the single sector given by address bits 16..14. Only that sector is erased. Sector n covers n*4000h to n*4000h+3FFFh.
- R6: Further 30h writes inside the window add their sectors to `erase_sectors`, and all selected sectors are erased.
- R7: The window is WIN_CYC clock cycles. It restarts on each accepted sector command. When it expires, `erase_busy` rises and status bit 3 (D3) reads 1. While the window is open, D3 reads 0.
- R8: A sector command written after D3 has gone high is not taken, and that sector keeps its data.
- R9: A write that does not fit the expected sequence returns the decoder to the read state, and the partial sequence is lost.
- R10: While the window is open or an erase runs, a read returns status. Bit 7 is 0, bit 3 is D3, and bit 6 changes value between successive reads.
- R11: Writes during an erase have no effect. `erase_busy` and `erase_sectors` keep their values.
- R12: `dout_en` is 1 only while ce_n=0 and oe_n=0, and `dout` is 0 when it is not. With ce_n=1, toggling oe_n has no effect, so it does not flip status bit 6.
- R13: When the busy time of BUSY_CYC cycles ends, `erase_busy` falls and reads return array data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data or status byte; 0 when not driven |
| dout_en | output | 1 | Output driver enable (high means drive, low means high impedance) |
| erase_busy | output | 1 | Erase operation in progress |
| erase_sectors | output | 8 | Sectors selected for the pending or running erase |

## Verification
The hardest case to reach is the sector window restart. The window has to be shown both to stay open longer than WIN_CYC after the first sector command, and to close WIN_CYC cycles after the last one. The bench adds a second sector part way through the first window. It checks that `erase_busy` is still low once more than WIN_CYC cycles have passed since the first command, and high soon after the second command's window expires. A late sector command and an unlock write are then issued during the erase. The bench reads back the late sector afterwards to show the command was dropped.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_SETUP,
        ST_UNL4,
        ST_UNL5,
        ST_SECT_WIN,
        ST_ERASE
    } cmd_state_t;

    localparam logic [16:0] UNLOCK_ADDR_A = 17'h05555;
    localparam logic [16:0] UNLOCK_ADDR_B = 17'h02AAA;

    localparam logic [7:0] CODE_UNLOCK1 = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK2 = 8'h55;
    localparam logic [7:0] CODE_SETUP   = 8'h80;
    localparam logic [7:0] CODE_CHIP    = 8'h10;
    localparam logic [7:0] CODE_SECTOR  = 8'h30;

endpackage

// File: rtl/bus_cycle_detect.sv
module bus_cycle_detect #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_commit,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_en,
    output logic          rd_done
);

    logic wr_act, wr_q, rd_q;

    assign wr_act = !ce_n && !we_n && oe_n;
    assign rd_en  = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_en;
            if (wr_act && !wr_q) wr_addr <= addr;
            if (wr_act)          wr_data <= din;
        end
    end

    assign wr_commit = wr_q && !wr_act;
    assign rd_done   = rd_q && !rd_en;

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && wr_act) |=> $stable(wr_addr));

endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 17,
    parameter int NSECT    = 8,
    parameter int WIN_CYC  = 16,
    parameter int BUSY_CYC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_commit,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    output logic [NSECT-1:0] sect_sel,
    output logic             erase_done,
    output logic             in_window,
    output logic             in_erase
);

    localparam int SW   = $clog2(NSECT);
    localparam int CMAX = (WIN_CYC > BUSY_CYC) ? WIN_CYC : BUSY_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    cmd_state_t       state, state_n;
    logic [CW-1:0]    cnt, cnt_n;
    logic [NSECT-1:0] sel_n, sect_bit;
    logic             hit_a, hit_b;

    assign sect_bit = NSECT'(1) << wr_addr[AW-1 -: SW];
    assign hit_a    = (wr_addr == AW'(UNLOCK_ADDR_A));
    assign hit_b    = (wr_addr == AW'(UNLOCK_ADDR_B));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READ;
            cnt      <= '0;
            sect_sel <= '0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            sect_sel <= sel_n;
        end
    end

    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        sel_n      = sect_sel;
        erase_done = 1'b0;
        unique case (state)
            ST_READ: begin
                if (wr_commit && hit_a && wr_data == CODE_UNLOCK1) state_n = ST_UNL1;
            end
            ST_UNL1: begin
                if (wr_commit)
                    state_n = (hit_b && wr_data == CODE_UNLOCK2) ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_commit)
                    state_n = (hit_a && wr_data == CODE_SETUP) ? ST_SETUP : ST_READ;
            end
            ST_SETUP: begin
                if (wr_commit)
                    state_n = (hit_a && wr_data == CODE_UNLOCK1) ? ST_UNL4 : ST_READ;
            end
            ST_UNL4: begin
                if (wr_commit)
                    state_n = (hit_b && wr_data == CODE_UNLOCK2) ? ST_UNL5 : ST_READ;
            end
            ST_UNL5: begin
                if (wr_commit) begin
                    if (hit_a && wr_data == CODE_CHIP) begin
                        state_n = ST_ERASE;
                        sel_n   = '1;
                        cnt_n   = CW'(BUSY_CYC - 1);
                    end else if (wr_data == CODE_SECTOR) begin
                        state_n = ST_SECT_WIN;
                        sel_n   = sect_bit;
                        cnt_n   = CW'(WIN_CYC - 1);
                    end else begin
                        state_n = ST_READ;
                    end
                end
            end
            ST_SECT_WIN: begin
                if (wr_commit) begin
                    if (wr_data == CODE_SECTOR) begin
                        sel_n = sect_sel | sect_bit;
                        cnt_n = CW'(WIN_CYC - 1);
                    end else begin
                        state_n = ST_READ;
                        sel_n   = '0;
                    end
                end else if (cnt == '0) begin
                    state_n = ST_ERASE;
                    cnt_n   = CW'(BUSY_CYC - 1);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_ERASE: begin
                if (cnt == '0) begin
                    state_n    = ST_READ;
                    sel_n      = '0;
                    erase_done = 1'b1;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        in_window = (state == ST_SECT_WIN);
        in_erase  = (state == ST_ERASE);
    end

    a_r11_erase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && cnt != '0) |=> (state == ST_ERASE && $stable(sect_sel)));

    a_r7_erase_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && $past(state) != ST_ERASE) |->
        ($past(state) == ST_SECT_WIN || $past(state) == ST_UNL5));

    a_r5_first_sector_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNL5 && wr_commit && wr_data == CODE_SECTOR && !hit_a) |=>
        ($countones(sect_sel) == 1));

    a_r9_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ERASE && state != ST_SECT_WIN) |-> (sect_sel == '0));

endmodule

// File: rtl/array_stub.sv
module array_stub #(
    parameter int AW    = 17,
    parameter int NSECT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic             erase_done,
    input  logic [NSECT-1:0] sect_sel,
    output logic [7:0]       rd_data
);

    localparam int SW = $clog2(NSECT);

    logic [NSECT-1:0] erased;
    logic [7:0]       fold;

    always_comb begin
        fold = '0;
        for (int i = 0; i < AW; i++) fold[i % 8] = fold[i % 8] ^ rd_addr[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          erased <= '0;
        else if (erase_done) erased <= erased | sect_sel;
    end

    assign rd_data = erased[rd_addr[AW-1 -: SW]] ? 8'hFF : fold;

    a_r13_marks_erased: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> ((erased & $past(sect_sel)) == $past(sect_sel)));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W   = 17,
    parameter int NUM_SECT = 8,
    parameter int WIN_CYC  = 16,
    parameter int BUSY_CYC = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          din,
    output logic [7:0]          dout,
    output logic                dout_en,
    output logic                erase_busy,
    output logic [NUM_SECT-1:0] erase_sectors
);

    localparam int DW = 8;

    logic              wr_commit, rd_done, rd_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DW-1:0]     wr_data, arr_data, status;
    logic              erase_done, in_window, in_erase, status_tgl;

    bus_cycle_detect #(.AW(ADDR_W), .DW(DW)) i_bus (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_commit(wr_commit), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_done(rd_done)
    );

    cmd_fsm #(.AW(ADDR_W), .NSECT(NUM_SECT), .WIN_CYC(WIN_CYC), .BUSY_CYC(BUSY_CYC)) i_fsm (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_addr(wr_addr),
        .wr_data(wr_data), .sect_sel(erase_sectors), .erase_done(erase_done),
        .in_window(in_window), .in_erase(in_erase)
    );

    array_stub #(.AW(ADDR_W), .NSECT(NUM_SECT)) i_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .erase_done(erase_done),
        .sect_sel(erase_sectors), .rd_data(arr_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       status_tgl <= 1'b0;
        else if (rd_done) status_tgl <= !status_tgl;
    end

    assign status     = {1'b0, status_tgl, 2'b00, in_erase, 3'b000};
    assign erase_busy = in_erase;
    assign dout_en    = rd_en;
    assign dout       = !rd_en ? '0 : ((in_window || in_erase) ? status : arr_data);

    a_r10_d3_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && erase_busy) |-> (dout[3] && !dout[7]));

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam int WIN  = 16;
    localparam int BUSY = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, erase_busy;
    logic [7:0]  erase_sectors;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = !clk;

    flash_cmd_decoder #(.WIN_CYC(WIN), .BUSY_CYC(BUSY)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .erase_busy(erase_busy), .erase_sectors(erase_sectors)
    );

    // {address, sector, fold pattern}
    localparam logic [27:0] VEC [0:5] = '{
        {17'h00012, 3'd0, 8'h12},
        {17'h04321, 3'd1, 8'h62},
        {17'h0A5A0, 3'd2, 8'h05},
        {17'h1C0F0, 3'd7, 8'h31},
        {17'h13C3C, 3'd4, 8'h01},
        {17'h17E11, 3'd5, 8'h6E}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_read(input logic [16:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d = dout;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic unlock5();
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'h80);
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] rd, s1, s2;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 busy", 16'(erase_busy), 16'h0);
        check("R1 sectors", 16'(erase_sectors), 16'h0);
        check("R12 en idle", 16'(dout_en), 16'h0);
        for (int i = 0; i < 6; i++) begin
            bus_read(VEC[i][27:11], rd);
            check("R1 array read", 16'(rd), 16'(VEC[i][7:0]));
        end

        // R12: CE high with OE low releases outputs
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        check("R12 dout_en", 16'(dout_en), 16'h0);
        check("R12 dout", 16'(dout), 16'h0);
        oe_n = 1'b1;

        // R2: first unlock with OE low is not a write
        @(negedge clk); addr = 17'h05555; din = 8'hAA; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        idle(2);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'h80);
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h0A5A0, 8'h30);
        idle(3);
        check("R2 no window", 16'(erase_sectors), 16'h0);
        idle(WIN + 4);
        check("R2 no erase", 16'(erase_busy), 16'h0);
        bus_read(17'h0A5A0, rd);
        check("R2 array intact", 16'(rd), 16'h05);

        // R9: wrong third write aborts the sequence
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'h00);
        bus_write(17'h05555, 8'h80);
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h0A5A0, 8'h30);
        idle(3);
        check("R9 no window", 16'(erase_sectors), 16'h0);
        idle(WIN + 4);
        check("R9 no erase", 16'(erase_busy), 16'h0);

        // R3: address from first cycle, data from last cycle
        @(negedge clk); addr = 17'h05555; din = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); addr = 17'h00000; din = 8'hAA;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'h80);
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h0A5A0, 8'h30);
        idle(1);
        check("R3 R5 one sector", 16'(erase_sectors), 16'h04);
        bus_read(17'h0A5A0, rd);
        check("R10 window bit7", 16'(rd[7]), 16'h0);
        check("R7 D3 low in window", 16'(rd[3]), 16'h0);
        idle(6);
        bus_write(17'h17E11, 8'h30);
        idle(1);
        check("R6 second sector", 16'(erase_sectors), 16'h24);
        idle(9);
        check("R7 window restarted", 16'(erase_busy), 16'h0);
        idle(10);
        check("R7 erase after window", 16'(erase_busy), 16'h1);
        bus_read(17'h00012, s1);
        check("R7 D3 high", 16'(s1[3]), 16'h1);
        check("R10 bit7 low", 16'(s1[7]), 16'h0);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        idle(2);
        oe_n = 1'b1;
        bus_read(17'h00012, s2);
        check("R10 R12 bit6 toggles once", 16'(s1[6] ^ s2[6]), 16'h1);

        // R8/R11: late sector and unlock during erase are ignored
        bus_write(17'h1A000, 8'h30);
        bus_write(17'h05555, 8'hAA);
        idle(1);
        check("R11 busy kept", 16'(erase_busy), 16'h1);
        check("R11 sectors kept", 16'(erase_sectors), 16'h24);
        idle(BUSY + 5);
        check("R13 busy falls", 16'(erase_busy), 16'h0);
        for (int i = 0; i < 6; i++) begin
            bus_read(VEC[i][27:11], rd);
            check("R5 R6 R13 after sector erase", 16'(rd),
                  (VEC[i][10:8] == 3'd2 || VEC[i][10:8] == 3'd5) ? 16'hFF : 16'(VEC[i][7:0]));
        end
        bus_read(17'h1A000, rd);
        check("R8 late sector kept", 16'(rd), 16'hA1);

        // R4: chip erase
        unlock5();
        bus_write(17'h05555, 8'h10);
        idle(1);
        check("R4 busy", 16'(erase_busy), 16'h1);
        check("R4 all sectors", 16'(erase_sectors), 16'hFF);
        idle(BUSY + 5);
        check("R13 chip done", 16'(erase_busy), 16'h0);
        for (int i = 0; i < 6; i++) begin
            bus_read(VEC[i][27:11], rd);
            check("R4 erased", 16'(rd), 16'hFF);
        end

        // R1: reset clears sector marks and returns to read
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        bus_read(17'h04321, rd);
        check("R1 after reset", 16'(rd), 16'h62);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule